// File: doc/BRIEF.md
# Four-Moduli Residue-to-Binary Converter

This block turns a number held as four residues back into plain binary. The residues are taken modulo 2^(N-1)-1, 2^(N+1)-1, 2^N-1 and 2^N. Together these moduli cover a range of M = P * 2^N, where P = (2^(N-1)-1)(2^(N+1)-1)(2^N-1). That is close to 4N bits. The block sits at the output of a residue arithmetic datapath. It accepts one residue tuple per cycle with a valid strobe and returns the matching integer two cycles later.

The conversion uses mixed-radix digits and runs in two registered levels:

- **First level.** It merges the three residues whose moduli are one less than a power of two. This gives a partial value X1 in [0, P). Every reduction on this level is an end-around-carry fold. The all-ones pattern is treated as zero.
- **Second level.** It treats P and 2^N as a pair of moduli. It forms X = X1 + P * (((r_pow - X1) * P^-1) mod 2^N). Reducing modulo 2^N is plain truncation.

All modular inverses are constants computed at elaboration. N must be even, so that the three odd moduli are pairwise coprime. N must also lie between 4 and 16. Any other value stops elaboration with an error.

Top module: `rns4_to_bin`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid` low and `bin_out` all zero.
- R2: `out_valid` equals `in_valid` as sampled two rising edges earlier. A gap in the input gives a gap in the output of the same length.
- R3: For canonical residues of an integer X with 0 <= X < M, the `bin_out` that goes with them equals X.
- R4: Bits [N-1:0] of a valid result equal the residue modulo 2^N that was supplied with it.
- R5: Every valid result is below M = P * 2^N. The first-level partial value is below P.
- R6: When no conversion completes in a cycle, `bin_out` keeps its previous value.
- R7: Tuples presented on consecutive cycles each produce their own correct result, one per cycle, in arrival order.
- R8: A valid result, reduced modulo each of 2^(N-1)-1, 2^(N+1)-1 and 2^N-1, gives back the residue supplied on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Residue tuple on the inputs is valid |
| res_lo | input | N-1 | Residue modulo 2^(N-1)-1 |
| res_hi | input | N+1 | Residue modulo 2^(N+1)-1 |
| res_mid | input | N | Residue modulo 2^N-1 |
| res_pow | input | N | Residue modulo 2^N |
| out_valid | output | 1 | `bin_out` holds a new result |
| bin_out | output | 4N | Reconstructed binary integer |

## Verification
On every cycle, the assertions check the following:

- The two-stage valid pipeline and the reset clear.
- That the first-level partial value stays below P and reduces back to each odd residue it came from.
- That the final value keeps the power-of-two residue in its low bits, stays below M, and reduces to the partial value modulo P.
- That the output holds when idle.

Only the bench scenarios can show that the whole integer is recovered exactly. They do this across random values over the full range for N = 4 and N = 6, and at the corners 0, 1, P-1, P and M-1. The scenarios also cover long back-to-back runs, where a wrong inverse constant or a dropped end-around carry would otherwise go unnoticed.

// File: rtl/rns4_pkg.sv
package rns4_pkg;

  typedef logic [63:0] wide_t;

  // Reduce v modulo 2^k-1 by folding k-bit chunks with end-around carry.
  // Callers pass at most about 3k significant bits; six folds settle that.
  function automatic wide_t eac_fold(wide_t v, int unsigned k);
    wide_t mask;
    wide_t acc;
    mask = (wide_t'(1) << k) - wide_t'(1);
    acc  = v;
    for (int i = 0; i < 6; i++) begin
      acc = (acc & mask) + (acc >> k);
    end
    if (acc == mask) acc = '0;
    return acc;
  endfunction

  // (a - b) mod 2^k-1: add the ones' complement of b and fold.
  function automatic wide_t eac_sub(wide_t a, wide_t b, int unsigned k);
    wide_t mask;
    mask = (wide_t'(1) << k) - wide_t'(1);
    return eac_fold(a + (~b & mask), k);
  endfunction

  // (a * c) mod 2^k-1 for a constant c below the modulus.
  function automatic wide_t eac_mulc(wide_t a, wide_t c, int unsigned k);
    return eac_fold(a * c, k);
  endfunction

  // Multiplicative inverse of a modulo m by the extended Euclid loop.
  function automatic longint mod_inv(longint a, longint m);
    longint t, nt, r, nr, q, tmp;
    t  = 0;
    nt = 1;
    r  = m;
    nr = a % m;
    while (nr != 0) begin
      q   = r / nr;
      tmp = t - q * nt;
      t   = nt;
      nt  = tmp;
      tmp = r - q * nr;
      r   = nr;
      nr  = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

endpackage

// File: rtl/rns4_mrc_lvl1.sv
module rns4_mrc_lvl1
  import rns4_pkg::*;
#(
  parameter int N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N-2:0]     r_lo,
  input  logic [N:0]       r_hi,
  input  logic [N-1:0]     r_mid,
  input  logic [N-1:0]     r_pow,
  output logic             out_valid,
  output logic [3*N-1:0]   x1,
  output logic [N-1:0]     pow_q
);
  localparam int    K_LO   = N - 1;
  localparam int    K_HI   = N + 1;
  localparam int    K_MID  = N;
  localparam int    PW     = 3 * N;
  localparam wide_t M_LO   = (wide_t'(1) << K_LO)  - wide_t'(1);
  localparam wide_t M_HI   = (wide_t'(1) << K_HI)  - wide_t'(1);
  localparam wide_t M_MID  = (wide_t'(1) << K_MID) - wide_t'(1);
  localparam wide_t P_ALL  = M_LO * M_HI * M_MID;
  // Mixed-radix order: mid modulus first, then lo, then hi.
  localparam wide_t INV_MID_LO = wide_t'(mod_inv(longint'(M_MID % M_LO), longint'(M_LO)));
  localparam wide_t INV_MID_HI = wide_t'(mod_inv(longint'(M_MID % M_HI), longint'(M_HI)));
  localparam wide_t INV_LO_HI  = wide_t'(mod_inv(longint'(M_LO % M_HI), longint'(M_HI)));

  // Named intermediate digits
  logic [K_MID-1:0] dig0;
  logic [K_LO-1:0]  mid_as_lo;
  logic [K_LO-1:0]  dig1;
  logic [K_HI-1:0]  hi_part;
  logic [K_HI-1:0]  dig2;
  logic [PW-1:0]    x1_d;

  logic             vld_q;
  logic [PW-1:0]    x1_q;
  logic [N-1:0]     pow_r;

  always_comb begin
    dig0      = r_mid;
    mid_as_lo = K_LO'(eac_fold(wide_t'(r_mid), K_LO));
    dig1      = K_LO'(eac_mulc(eac_sub(wide_t'(r_lo), wide_t'(mid_as_lo), K_LO),
                               INV_MID_LO, K_LO));
    hi_part   = K_HI'(eac_mulc(eac_sub(wide_t'(r_hi), wide_t'(r_mid), K_HI),
                               INV_MID_HI, K_HI));
    dig2      = K_HI'(eac_mulc(eac_sub(wide_t'(hi_part), wide_t'(dig1), K_HI),
                               INV_LO_HI, K_HI));
    x1_d      = PW'(wide_t'(dig0)
                  + M_MID * wide_t'(dig1)
                  + M_MID * M_LO * wide_t'(dig2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      x1_q  <= '0;
      pow_r <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        x1_q  <= x1_d;
        pow_r <= r_pow;
      end
    end
  end

  assign out_valid = vld_q;
  assign x1        = x1_q;
  assign pow_q     = pow_r;

  AST_X1_BELOW_P: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (wide_t'(x1_q) < P_ALL)); // R5
  AST_X1_MOD_MID: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ((wide_t'(x1_q) % M_MID) == wide_t'($past(r_mid)))); // R8
  AST_X1_MOD_LO: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ((wide_t'(x1_q) % M_LO) == wide_t'($past(r_lo)))); // R8
  AST_X1_MOD_HI: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ((wide_t'(x1_q) % M_HI) == wide_t'($past(r_hi)))); // R8

endmodule

// File: rtl/rns4_mrc_lvl2.sv
module rns4_mrc_lvl2
  import rns4_pkg::*;
#(
  parameter int N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3*N-1:0]   x1,
  input  logic [N-1:0]     r_pow,
  output logic             out_valid,
  output logic [4*N-1:0]   bin
);
  localparam int    PW      = 3 * N;
  localparam int    XW      = 4 * N;
  localparam wide_t M_LO    = (wide_t'(1) << (N - 1)) - wide_t'(1);
  localparam wide_t M_HI    = (wide_t'(1) << (N + 1)) - wide_t'(1);
  localparam wide_t M_MID   = (wide_t'(1) << N) - wide_t'(1);
  localparam wide_t P_ALL   = M_LO * M_HI * M_MID;
  localparam wide_t POW     = wide_t'(1) << N;
  localparam wide_t M_TOTAL = P_ALL << N;
  localparam logic [N-1:0]  P_INV = N'(mod_inv(longint'(P_ALL % POW), longint'(POW)));
  localparam logic [XW-1:0] P_W   = XW'(P_ALL);

  logic [N-1:0]  gap;
  logic [N-1:0]  top_digit;
  logic [XW-1:0] bin_d;
  logic          vld_q;
  logic [XW-1:0] bin_q;

  always_comb begin
    gap       = r_pow - x1[N-1:0];        // modulo 2^N by truncation
    top_digit = N'(gap * P_INV);
    bin_d     = XW'(x1) + P_W * XW'(top_digit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      bin_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) bin_q <= bin_d;
    end
  end

  assign out_valid = vld_q;
  assign bin       = bin_q;

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (bin_q[N-1:0] == $past(r_pow))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (wide_t'(bin_q) < M_TOTAL)); // R5
  AST_MOD_P: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ((wide_t'(bin_q) % P_ALL) == wide_t'($past(x1)))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(bin_q)); // R6

endmodule

// File: rtl/rns4_to_bin.sv
module rns4_to_bin #(
  parameter int N = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-2:0]   res_lo,
  input  logic [N:0]     res_hi,
  input  logic [N-1:0]   res_mid,
  input  logic [N-1:0]   res_pow,
  output logic           out_valid,
  output logic [4*N-1:0] bin_out
);
  localparam int PW = 3 * N;

  if ((N % 2) != 0 || N < 4 || N > 16) begin : g_bad_width
    $error("rns4_to_bin: N must be even and within 4..16");
  end

  // Inter-level signals
  logic          s1_valid;
  logic [PW-1:0] s1_x1;
  logic [N-1:0]  s1_pow;

  rns4_mrc_lvl1 #(.N(N)) u_lvl1 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .r_lo      (res_lo),
    .r_hi      (res_hi),
    .r_mid     (res_mid),
    .r_pow     (res_pow),
    .out_valid (s1_valid),
    .x1        (s1_x1),
    .pow_q     (s1_pow)
  );

  rns4_mrc_lvl2 #(.N(N)) u_lvl2 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .x1        (s1_x1),
    .r_pow     (s1_pow),
    .out_valid (out_valid),
    .bin       (bin_out)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && (bin_out == '0))); // R1
  AST_PIPE_L1_ON: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R2
  AST_PIPE_L1_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid); // R2
  AST_PIPE_L2_ON: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R2
  AST_PIPE_L2_OFF: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid); // R2

endmodule

// File: tb/rns4_to_bin_test.sv
module rns4_to_bin_test;

  // Lane A uses N = 6, lane B uses N = 4.
  localparam longint A_LO = 31, A_HI = 127, A_MID = 63, A_POW = 64;
  localparam longint B_LO = 7,  B_HI = 31,  B_MID = 15, B_POW = 16;
  localparam longint A_P = A_LO * A_HI * A_MID;
  localparam longint B_P = B_LO * B_HI * B_MID;
  localparam longint A_M = A_P * A_POW;
  localparam longint B_M = B_P * B_POW;

  logic clk = 1'b0;
  logic rst;
  always #2.5ns clk = ~clk;

  logic        a_vld, a_ov;
  logic [4:0]  a_lo;
  logic [6:0]  a_hi;
  logic [5:0]  a_mid, a_pow;
  logic [23:0] a_x;

  logic        b_vld, b_ov;
  logic [2:0]  b_lo;
  logic [4:0]  b_hi;
  logic [3:0]  b_mid, b_pow;
  logic [15:0] b_x;

  rns4_to_bin #(.N(6)) uut (
    .clk(clk), .rst(rst), .in_valid(a_vld),
    .res_lo(a_lo), .res_hi(a_hi), .res_mid(a_mid), .res_pow(a_pow),
    .out_valid(a_ov), .bin_out(a_x)
  );

  rns4_to_bin #(.N(4)) uut_n4 (
    .clk(clk), .rst(rst), .in_valid(b_vld),
    .res_lo(b_lo), .res_hi(b_hi), .res_mid(b_mid), .res_pow(b_pow),
    .out_valid(b_ov), .bin_out(b_x)
  );

  int     checks = 0;
  int     errors = 0;
  bit     pa_v [2];
  longint pa_x [2];
  bit     pb_v [2];
  longint pb_x [2];
  longint a_last = 0;
  longint b_last = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lane_check(input bit ov, input longint x, input bit ev, input longint ex,
                            input longint mlo, input longint mhi, input longint mmid,
                            input longint mpow, input longint mtot,
                            inout longint last, input string req_main);
    chk(ov == ev, "R2 valid delay", longint'(ov), longint'(ev));
    if (ev) begin
      chk(x == ex, req_main, x, ex);
      chk((x % mpow) == (ex % mpow), "R4 low bits", x % mpow, ex % mpow);
      chk(x < mtot, "R5 range", x, mtot - 1);
      chk((x % mlo) == (ex % mlo) && (x % mhi) == (ex % mhi) && (x % mmid) == (ex % mmid),
          "R8 odd residues", x, ex);
      last = x;
    end else begin
      chk(x == last, "R6 hold", x, last);
    end
  endtask

  // Check the outputs due at this negedge, then drive the next tuple.
  task automatic step(input bit va, input longint xa, input bit vb, input longint xb,
                      input string req_main);
    @(negedge clk);
    lane_check(a_ov, longint'(a_x), pa_v[1], pa_x[1], A_LO, A_HI, A_MID, A_POW, A_M,
               a_last, req_main);
    lane_check(b_ov, longint'(b_x), pb_v[1], pb_x[1], B_LO, B_HI, B_MID, B_POW, B_M,
               b_last, req_main);
    pa_v[1] = pa_v[0]; pa_x[1] = pa_x[0]; pa_v[0] = va; pa_x[0] = xa;
    pb_v[1] = pb_v[0]; pb_x[1] = pb_x[0]; pb_v[0] = vb; pb_x[0] = xb;
    a_vld = va;
    a_lo  = 5'(xa % A_LO);
    a_hi  = 7'(xa % A_HI);
    a_mid = 6'(xa % A_MID);
    a_pow = 6'(xa % A_POW);
    b_vld = vb;
    b_lo  = 3'(xb % B_LO);
    b_hi  = 5'(xb % B_HI);
    b_mid = 4'(xb % B_MID);
    b_pow = 4'(xb % B_POW);
  endtask

  function automatic longint rnd_below(longint m);
    return longint'($urandom) % m;
  endfunction

  initial begin
    #900us;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 2; i++) begin
      pa_v[i] = 1'b0; pa_x[i] = 0; pb_v[i] = 1'b0; pb_x[i] = 0;
    end
    rst = 1'b1;
    a_vld = 1'b0; a_lo = '0; a_hi = '0; a_mid = '0; a_pow = '0;
    b_vld = 1'b0; b_lo = '0; b_hi = '0; b_mid = '0; b_pow = '0;
    repeat (3) @(negedge clk);
    // R1: reset state on both lanes
    chk(!a_ov && a_x == '0, "R1 reset N=6", longint'(a_x), 0);
    chk(!b_ov && b_x == '0, "R1 reset N=4", longint'(b_x), 0);
    rst = 1'b0;

    // R3 corners: zero, one, P-1, P, 2^N-1, 2^N, M-1
    step(1, 0,         1, 0,         "R3 zero");
    step(1, 1,         1, 1,         "R3 one");
    step(1, A_P - 1,   1, B_P - 1,   "R3 P-1");
    step(1, A_P,       1, B_P,       "R3 P");
    step(0, 0,         0, 0,         "R3 gap");
    step(1, A_POW - 1, 1, B_POW - 1, "R3 2^N-1");
    step(1, A_POW,     1, B_POW,     "R3 2^N");
    step(1, A_M - 1,   1, B_M - 1,   "R3 M-1");
    step(0, 5,         0, 5,         "R3 gap");
    step(0, 9,         0, 9,         "R3 gap");

    // R3 with sparse random valid pattern; R6 on the idle cycles
    for (int i = 0; i < 1500; i++) begin
      step(($urandom % 3) != 0, rnd_below(A_M), ($urandom % 3) != 0, rnd_below(B_M),
           "R3 random");
    end

    // R7: back-to-back tuples, one per cycle
    for (int i = 0; i < 400; i++) begin
      step(1, rnd_below(A_M), 1, rnd_below(B_M), "R7 back-to-back");
    end

    // Drain the pipeline and confirm the idle hold
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R6 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule